// File: doc/BRIEF.md
# Interrupt Destination Address Matcher

This block decides whether an interrupt message arriving at an interrupt controller is addressed to that controller. Each message carries an 8-bit destination field and a mode bit. In physical mode the destination is compared exactly against the local identifier. In logical mode the destination is compared against a local logical-destination register. That comparison uses either flat addressing, where any common set bit selects the unit, or cluster addressing, where the upper nibble names a cluster exactly and the lower nibble selects members by overlap. An all-ones destination is a broadcast in every mode.

A message is presented with a one-cycle valid strobe. The verdict comes out one clock later as a registered accept flag and a registered broadcast flag. A small state machine sequences this. From IDLE it moves to DECIDE on the transition `msg_seen`. From DECIDE it goes back to IDLE on `no_msg`, or stays in DECIDE on `msg_again` when another strobe arrives back to back. Both outputs are driven only in DECIDE, so they stay low whenever the previous cycle carried no message.

Top module: `dest_match_top`

## Requirements
- R1: After reset, `accept_o` and `bcast_o` are 0, and they remain 0 until one cycle after the first `msg_valid_i`.
- R2: In the cycle after a cycle with `msg_valid_i`=0, both `accept_o` and `bcast_o` are 0.
- R3: Physical mode (`dest_mode_i`=0) with a destination other than 8'hFF: `accept_o` is 1 one cycle later exactly when the destination equals `local_id_i`.
- R4: A destination of 8'hFF in any mode and any format gives `accept_o`=1 and `bcast_o`=1 one cycle later. Any other destination gives `bcast_o`=0.
- R5: Logical mode (`dest_mode_i`=1) with `fmt_i`=4'hF (flat): `accept_o` is 1 exactly when `dest_i & log_dest_i` is nonzero.
- R6: Logical mode with `fmt_i`=4'h0 (cluster): `accept_o` is 1 exactly when `dest_i[7:4]` equals `log_dest_i[7:4]` and `dest_i[3:0] & log_dest_i[3:0]` is nonzero.
- R7: Logical mode with any `fmt_i` value other than 4'hF is matched by the cluster rule.
- R8: Back-to-back strobes each yield their own verdict in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| msg_valid_i | input | 1 | Message present this cycle |
| dest_i | input | 8 | Message destination field |
| dest_mode_i | input | 1 | 0 = physical, 1 = logical |
| local_id_i | input | 8 | Local physical identifier |
| log_dest_i | input | 8 | Local logical destination |
| fmt_i | input | 4 | Logical format: 4'hF flat, otherwise cluster |
| accept_o | output | 1 | Message accepted (one cycle after strobe) |
| bcast_o | output | 1 | Message was a broadcast (one cycle after strobe) |

## Verification
The bench sweeps every destination value against several local identifiers and logical registers in physical mode, flat mode and cluster mode. This exposes a design that decodes 8'hFF as an ordinary address, which would drop broadcasts in cluster mode, or that matches a whole cluster whose member bits do not overlap. Formats other than 4'hF and 4'h0 are tried, which catches a decoder that treats unknown formats as flat. Gaps between strobes reveal outputs that hold a stale verdict instead of dropping to 0. Back-to-back strobes reveal a pipeline that loses the second message.

// File: rtl/dest_match_pkg.sv
package dest_match_pkg;
    parameter int unsigned ADDR_W = 8;
    localparam int unsigned NIB_W = ADDR_W / 2;
    parameter int unsigned FMT_W = 4;
    localparam logic [FMT_W-1:0] FMT_FLAT = '1;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_DECIDE = 1'b1
    } match_state_e;

    typedef struct packed {
        logic accept;
        logic bcast;
    } verdict_t;
endpackage

// File: rtl/dest_match_logic.sv
module dest_match_logic
    import dest_match_pkg::*;
(
    input  logic [ADDR_W-1:0] dest_i,
    input  logic              dest_mode_i,
    input  logic [ADDR_W-1:0] local_id_i,
    input  logic [ADDR_W-1:0] log_dest_i,
    input  logic [FMT_W-1:0]  fmt_i,
    output verdict_t          verdict_o
);
    logic is_bcast;
    logic phys_hit;
    logic flat_hit;
    logic clus_hit;
    logic logic_hit;

    always_comb begin
        is_bcast  = &dest_i;
        phys_hit  = (dest_i == local_id_i);
        flat_hit  = |(dest_i & log_dest_i);
        clus_hit  = (dest_i[ADDR_W-1:NIB_W] == log_dest_i[ADDR_W-1:NIB_W]) &&
                    (|(dest_i[NIB_W-1:0] & log_dest_i[NIB_W-1:0]));
        logic_hit = (fmt_i == FMT_FLAT) ? flat_hit : clus_hit;
        verdict_o.bcast  = is_bcast;
        verdict_o.accept = is_bcast | (dest_mode_i ? logic_hit : phys_hit);
    end
endmodule

// File: rtl/dest_match_top.sv
module dest_match_top
    import dest_match_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              msg_valid_i,
    input  logic [ADDR_W-1:0] dest_i,
    input  logic              dest_mode_i,
    input  logic [ADDR_W-1:0] local_id_i,
    input  logic [ADDR_W-1:0] log_dest_i,
    input  logic [FMT_W-1:0]  fmt_i,
    output logic              accept_o,
    output logic              bcast_o
);
    match_state_e state_q, state_d;
    verdict_t     verdict_c, verdict_q;

    dest_match_logic u_logic (
        .dest_i      (dest_i),
        .dest_mode_i (dest_mode_i),
        .local_id_i  (local_id_i),
        .log_dest_i  (log_dest_i),
        .fmt_i       (fmt_i),
        .verdict_o   (verdict_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (msg_valid_i) state_d = ST_DECIDE;  // msg_seen
            ST_DECIDE: state_d = msg_valid_i ? ST_DECIDE : ST_IDLE; // msg_again / no_msg
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            verdict_q <= '0;
        end else begin
            state_q   <= state_d;
            verdict_q <= msg_valid_i ? verdict_c : '0;
        end
    end

    always_comb begin
        accept_o = 1'b0;
        bcast_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_DECIDE: begin
                accept_o = verdict_q.accept;
                bcast_o  = verdict_q.bcast;
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/dest_match_chk.sv
module dest_match_chk
    import dest_match_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              msg_valid_i,
    input logic [ADDR_W-1:0] dest_i,
    input logic              dest_mode_i,
    input logic [ADDR_W-1:0] local_id_i,
    input logic [FMT_W-1:0]  fmt_i,
    input logic              accept_o,
    input logic              bcast_o
);
    logic was_rst;
    always_ff @(posedge clk_i) was_rst <= !rst_ni;

    p_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || was_rst)
        !msg_valid_i |=> (!accept_o && !bcast_o));
    p_bcast_acc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || was_rst)
        bcast_o |-> accept_o);
    p_bcast_dest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || was_rst)
        (msg_valid_i && (&dest_i)) |=> (bcast_o && accept_o));
    p_phys_eq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || was_rst)
        (msg_valid_i && !dest_mode_i && dest_i == local_id_i) |=> accept_o);
    p_clus_nib_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || was_rst)
        (msg_valid_i && dest_mode_i && fmt_i != FMT_FLAT && !(&dest_i) &&
         dest_i[NIB_W-1:0] == '0) |=> !accept_o);
    p_reset_r1: assert property (@(posedge clk_i) was_rst |-> (!accept_o && !bcast_o));
endmodule

bind dest_match_top dest_match_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .msg_valid_i (msg_valid_i),
    .dest_i      (dest_i),
    .dest_mode_i (dest_mode_i),
    .local_id_i  (local_id_i),
    .fmt_i       (fmt_i),
    .accept_o    (accept_o),
    .bcast_o     (bcast_o)
);

// File: tb/test_dest_match_top.sv
module test_dest_match_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       msg_valid = 1'b0;
    logic [7:0] dest = '0;
    logic       dmode = 1'b0;
    logic [7:0] lid = '0;
    logic [7:0] ldest = '0;
    logic [3:0] fmt = 4'hF;
    logic       acc, bc;
    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    dest_match_top i_dest_match_top (
        .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(msg_valid), .dest_i(dest),
        .dest_mode_i(dmode), .local_id_i(lid), .log_dest_i(ldest), .fmt_i(fmt),
        .accept_o(acc), .bcast_o(bc)
    );

    function automatic logic model_acc(logic [7:0] d, logic m, logic [7:0] id,
                                       logic [7:0] ld, logic [3:0] f);
        if (d == 8'hFF) return 1'b1;
        if (!m) return d == id;
        if (f == 4'hF) return (d & ld) != 0;
        return (d[7:4] == ld[7:4]) && ((d[3:0] & ld[3:0]) != 0);
    endfunction

    task automatic chk(string req, logic a, logic b, logic ea, logic eb);
        checks++;
        if (a !== ea || b !== eb) begin
            fails++;
            $display("FAIL %s: acc=%b bc=%b expected acc=%b bc=%b (dest=%h mode=%b fmt=%h)",
                     req, a, b, ea, eb, dest, dmode, fmt);
        end
    endtask

    // Drive one strobe, then sample the registered verdict in the next cycle.
    task automatic send(string req, logic [7:0] d, logic m);
        @(negedge clk);
        dest = d; dmode = m; msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
        chk(req, acc, bc, model_acc(d, m, lid, ldest, fmt), d == 8'hFF);
    endtask

    initial begin
        #400000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", acc, bc, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", acc, bc, 0, 0);

        // R3 physical sweep, R4 broadcast included
        foreach (lid_set[k]) ;
        for (int k = 0; k < 3; k++) begin
            lid = (k == 0) ? 8'h00 : (k == 1) ? 8'h5A : 8'hFE;
            for (int d = 0; d < 256; d++) send(d == 255 ? "R4" : "R3", 8'(d), 1'b0);
        end
        // R5 flat sweep
        fmt = 4'hF;
        for (int k = 0; k < 3; k++) begin
            ldest = (k == 0) ? 8'h01 : (k == 1) ? 8'h80 : 8'h00;
            for (int d = 0; d < 256; d++) send(d == 255 ? "R4" : "R5", 8'(d), 1'b1);
        end
        // R6 cluster sweep
        fmt = 4'h0;
        for (int k = 0; k < 2; k++) begin
            ldest = (k == 0) ? 8'h32 : 8'hE9;
            for (int d = 0; d < 256; d++) send(d == 255 ? "R4" : "R6", 8'(d), 1'b1);
        end
        // R7 other formats use cluster rule
        ldest = 8'h41;
        for (int f = 1; f < 15; f++) begin
            fmt = 4'(f);
            send("R7", 8'h43, 1'b1);   // accepted: same cluster, overlap
            send("R7", 8'h51, 1'b1);   // rejected: other cluster (flat would accept)
        end
        // R2 idle gap
        @(negedge clk);
        chk("R2", acc, bc, 0, 0);
        // R8 back-to-back
        fmt = 4'hF; ldest = 8'h0F; lid = 8'h10;
        @(negedge clk);
        dest = 8'h01; dmode = 1'b1; msg_valid = 1'b1;
        @(negedge clk);
        chk("R8", acc, bc, 1, 0);
        dest = 8'hFF; dmode = 1'b0;
        @(negedge clk);
        chk("R8", acc, bc, 1, 1);
        dest = 8'h11; dmode = 1'b0;
        @(negedge clk);
        chk("R8", acc, bc, 0, 0);
        msg_valid = 1'b0;
        @(negedge clk);
        chk("R2", acc, bc, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    logic [0:0] lid_set;
endmodule